// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a host. Each line is latched as a request, edge- or level-sensitive by configuration, and can be masked. Requests are ranked by a rotating priority order. A request reaches the output only if it outranks every level already in service. The host reaches the block through an 8-bit port with two addresses. Address bit A0 = 0 is the command address and A0 = 1 is the data address.

After reset, or after an initialization sequence, the host services interrupts by polling. It writes a poll command, then reads the command address. That read returns the winning level and marks it in service. The host then ends service with an end-of-interrupt command. A special mask mode lets masked in-service levels stop blocking lower levels. A request on level 7 that drops before it is polled reads back as "nothing pending", and its in-service bit stays clear, so software can treat it as spurious. The stored configuration words can be read back, but they drive no external cascade bus.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at the data address, the request and in-service registers read 0x00, irq_out is low, and level 0 is highest with level 7 lowest.
- R2: A command-address write with bit 4 set starts initialization. It clears the mask to 0x00, the in-service register, special mask mode and the pending poll. It restores the default priority and the request read view. Bit 3 = 1 selects level triggering for all inputs. Bit 1 = 1 skips the cascade word. Bit 0 = 1 requests a mode word; when bit 0 = 0 the mode word is cleared. The following data-address writes load the vector base, then the cascade word if not skipped, then the mode word if requested. The next data-address write after the sequence loads the mask.
- R3: A select command with bit 7 = 1 makes command-address reads return a stored configuration word: bits 1..0 = 00 gives the vector base, 01 gives the cascade word, 10 gives the mode word.
- R4: Outside initialization, a data-address write loads the mask and a data-address read returns it. A 1 bit masks that input. A masked input still records its request but cannot raise irq_out; clearing the mask bit raises irq_out.
- R5: In edge mode a request bit is set only on a 0-to-1 transition of its input and is cleared when a poll services it. An input held high after service does not request again.
- R6: In level mode a request bit follows its input, one clock later, for as long as the input is held.
- R7: A command write with bits 4..3 = 01 and bit 2 = 1 arms a poll. The next command-address read returns bit 7 = pending, bits 6..3 = 0 and bits 2..0 = the winning level, and it sets that level's in-service bit. With nothing pending the read returns 0x00 and changes nothing.
- R8: The command 0xC0|L makes level L lowest and L+1 highest (0xC2 gives 3,4,5,6,7,0,1,2). A request is blocked by any in-service level of equal or higher priority.
- R9: The command 0x60|L clears exactly in-service bit L. The command 0x20 clears the highest-priority in-service bit. A lower pending request that was blocked then raises irq_out.
- R10: The select command 0x0A makes command-address reads return the request register; 0x0B makes them return the in-service register.
- R11: The select command 0x68 enables special mask mode and 0x48 disables it. In that mode an in-service level whose mask bit is set does not block lower levels.
- R12: In level mode, a level-7 request that drops before the poll yields a poll result of 0x00, and in-service bit 7 stays 0.
- R13: irq_out is high exactly when an unmasked request outranks all blocking in-service levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Interrupt request inputs, level 0..7 |
| bus_a0 | input | 1 | Address select: 0 command, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle, and that each access lasts one clock. They also assume irq_in changes only between clock edges. The bench drives every access from a single task, separated by idle cycles, and changes irq_in just after a rising edge. Register effects are therefore judged one edge after each access. The bench releases level 7 before the poll to create the spurious case.

// File: rtl/pic_pkg.sv
// Shared types for the priority interrupt controller.
// Assumes an 8-line controller addressed through an 8-bit port.
package pic_pkg;
    typedef enum logic [1:0] {
        INIT_IDLE,
        INIT_W2,
        INIT_W3,
        INIT_W4
    } init_st_t;

    typedef enum logic [2:0] {
        VIEW_IRR,
        VIEW_ISR,
        VIEW_VEC,
        VIEW_CAS,
        VIEW_MODE
    } view_t;
endpackage

// File: rtl/pic_req_latch.sv
// Request register: records edge- or level-sensitive requests per line.
// Assumes irq_in is synchronous to clk. A serviced edge request is
// cleared by svc_clr; clear_all drops every request and re-arms edges.
module pic_req_latch #(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              level_mode,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [NUM_IN-1:0] svc_clr,
    output logic [NUM_IN-1:0] irr
);
    logic [NUM_IN-1:0] prev_in;

    // Previous input sample, used to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_in <= '0;
        else        prev_in <= irq_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IN; gi++) begin : g_line
            // Per-line request bit update.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_all)         irr[gi] <= 1'b0;
                else if (level_mode)             irr[gi] <= irq_in[gi];
                else if (irq_in[gi] && !prev_in[gi]) irr[gi] <= 1'b1;
                else if (svc_clr[gi])            irr[gi] <= 1'b0;
            end

            // R5/R6: a request can only appear while its input was high.
            a_r5_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irr[gi]) |-> $past(irq_in[gi]));
        end
    endgenerate
endmodule

// File: rtl/pic_prio_resolve.sv
// Rotating priority resolver. Level lowest+1 ranks highest.
// Finds the top requested level and the top blocking level, and grants
// when the request strictly outranks the blocker. NUM_IN is a power of two.
module pic_prio_resolve #(
    parameter int NUM_IN = 8,
    localparam int ID_W = $clog2(NUM_IN)
) (
    input  logic [ID_W-1:0]   lowest,
    input  logic [NUM_IN-1:0] req,
    input  logic [NUM_IN-1:0] blk,
    output logic              req_hit,
    output logic [ID_W-1:0]   req_id,
    output logic              blk_hit,
    output logic [ID_W-1:0]   blk_id,
    output logic              grant
);
    logic [ID_W-1:0] req_rank, blk_rank, lvl;

    // Scan levels in priority order, keeping the first hit of each kind.
    always_comb begin
        req_hit = 1'b0; req_id = '0; req_rank = '0;
        blk_hit = 1'b0; blk_id = '0; blk_rank = '0;
        lvl = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            lvl = lowest + ID_W'(k + 1);
            if (!req_hit && req[lvl]) begin
                req_hit = 1'b1; req_id = lvl; req_rank = ID_W'(k);
            end
            if (!blk_hit && blk[lvl]) begin
                blk_hit = 1'b1; blk_id = lvl; blk_rank = ID_W'(k);
            end
        end
        grant = req_hit && (!blk_hit || (req_rank < blk_rank));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Programmable priority interrupt controller, serviced by poll reads.
// Assumes single-cycle bus strobes with bus_rd and bus_wr never together.
// Command address decodes init word 1 (bit 4), priority/EOI (bits 4..3=00)
// and select (bits 4..3=01). Data address carries init words or the mask.
module prio_irq_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] irq_in,
    input  logic              bus_a0,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    import pic_pkg::*;

    localparam int NUM_IN = DATA_W;
    localparam int ID_W   = $clog2(NUM_IN);
    localparam int PAD_W  = DATA_W - 1 - ID_W;

    logic [NUM_IN-1:0] irr, imr, isr, svc_clr, blk_eff;
    logic [ID_W-1:0]   lowest, req_id, blk_id, top_isr_id;
    logic              smm, level_mode, single_mode, need_w4, poll_armed;
    logic              req_hit, blk_hit, grant, top_isr_hit;
    logic              unused_req_hit, unused_grant;
    logic [ID_W-1:0]   unused_req_id;
    logic [DATA_W-1:0] vec_base, cas_word, mode_word, poll_word;
    init_st_t          init_st;
    view_t             view;

    logic wr_cmd, wr_dat, rd_cmd, is_icw1, is_prio, is_sel, poll_take;

    // Bus decode.
    always_comb begin
        wr_cmd    = bus_wr && !bus_a0;
        wr_dat    = bus_wr && bus_a0;
        rd_cmd    = bus_rd && !bus_a0 && !bus_wr;
        is_icw1   = wr_cmd && bus_wdata[4];
        is_prio   = wr_cmd && (bus_wdata[4:3] == 2'b00);
        is_sel    = wr_cmd && (bus_wdata[4:3] == 2'b01);
        poll_take = rd_cmd && poll_armed;
    end

    // Masked in-service levels stop blocking in special mask mode.
    always_comb blk_eff = smm ? (isr & ~imr) : isr;

    // Edge requests are consumed by a successful poll.
    always_comb svc_clr = (poll_take && grant) ? (NUM_IN'(1) << req_id) : '0;

    pic_req_latch #(.NUM_IN(NUM_IN)) u_req (
        .clk(clk), .rst_n(rst_n), .clear_all(is_icw1),
        .level_mode(level_mode), .irq_in(irq_in),
        .svc_clr(svc_clr), .irr(irr)
    );

    pic_prio_resolve #(.NUM_IN(NUM_IN)) u_arb (
        .lowest(lowest), .req(irr & ~imr), .blk(blk_eff),
        .req_hit(req_hit), .req_id(req_id),
        .blk_hit(blk_hit), .blk_id(blk_id), .grant(grant)
    );

    pic_prio_resolve #(.NUM_IN(NUM_IN)) u_eoi (
        .lowest(lowest), .req('0), .blk(isr),
        .req_hit(unused_req_hit), .req_id(unused_req_id),
        .blk_hit(top_isr_hit), .blk_id(top_isr_id), .grant(unused_grant)
    );

    // Initialization word sequencer and configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_st <= INIT_IDLE; level_mode <= 1'b0;
            single_mode <= 1'b0;  need_w4 <= 1'b0;
            vec_base <= '0; cas_word <= '0; mode_word <= '0;
        end else if (is_icw1) begin
            init_st     <= INIT_W2;
            level_mode  <= bus_wdata[3];
            single_mode <= bus_wdata[1];
            need_w4     <= bus_wdata[0];
            if (!bus_wdata[0]) mode_word <= '0;
        end else if (wr_dat) begin
            case (init_st)
                INIT_W2: begin
                    vec_base <= bus_wdata;
                    init_st  <= !single_mode ? INIT_W3 : (need_w4 ? INIT_W4 : INIT_IDLE);
                end
                INIT_W3: begin
                    cas_word <= bus_wdata;
                    init_st  <= need_w4 ? INIT_W4 : INIT_IDLE;
                end
                INIT_W4: begin
                    mode_word <= bus_wdata;
                    init_st   <= INIT_IDLE;
                end
                default: init_st <= INIT_IDLE;
            endcase
        end
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             imr <= '1;
        else if (is_icw1)                       imr <= '0;
        else if (wr_dat && init_st == INIT_IDLE) imr <= bus_wdata;
    end

    // In-service register: set by poll, cleared by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || is_icw1) begin
            isr <= '0;
        end else if (poll_take && grant) begin
            isr[req_id] <= 1'b1;
        end else if (is_prio) begin
            case (bus_wdata[7:5])
                3'b001:  if (top_isr_hit) isr[top_isr_id] <= 1'b0;
                3'b011:  isr[bus_wdata[ID_W-1:0]] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Operating state: priority, special mask, poll arm, read view.
    always_ff @(posedge clk) begin
        if (!rst_n || is_icw1) begin
            lowest <= ID_W'(NUM_IN - 1); smm <= 1'b0;
            poll_armed <= 1'b0;          view <= VIEW_IRR;
        end else begin
            if (is_prio && bus_wdata[7:5] == 3'b110) lowest <= bus_wdata[ID_W-1:0];
            if (is_sel) begin
                if (bus_wdata[6]) smm <= bus_wdata[5];
                poll_armed <= bus_wdata[2];
                if (bus_wdata[7]) begin
                    case (bus_wdata[1:0])
                        2'b00:   view <= VIEW_VEC;
                        2'b01:   view <= VIEW_CAS;
                        default: view <= VIEW_MODE;
                    endcase
                end else if (bus_wdata[1]) begin
                    view <= bus_wdata[0] ? VIEW_ISR : VIEW_IRR;
                end
            end else if (poll_take) begin
                poll_armed <= 1'b0;
            end
        end
    end

    // Poll result word.
    always_comb poll_word = grant ? {1'b1, {PAD_W{1'b0}}, req_id} : '0;

    // Read data mux.
    always_comb begin
        if (bus_a0)          bus_rdata = imr;
        else if (poll_armed) bus_rdata = poll_word;
        else begin
            case (view)
                VIEW_ISR:  bus_rdata = isr;
                VIEW_VEC:  bus_rdata = vec_base;
                VIEW_CAS:  bus_rdata = cas_word;
                VIEW_MODE: bus_rdata = mode_word;
                default:   bus_rdata = irr;
            endcase
        end
    end

    assign irq_out = grant;

    a_r7_poll_shape: assert property (@(posedge clk) disable iff (!rst_n)
        poll_take |-> (bus_rdata[DATA_W-2:ID_W] == '0) && (bus_rdata[DATA_W-1] || bus_rdata == '0));

    a_r7_poll_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_take && bus_rdata[DATA_W-1]) |=> isr[$past(bus_rdata[ID_W-1:0])]);

    a_r9_specific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prio && bus_wdata[7:5] == 3'b011) |=> !isr[$past(bus_wdata[ID_W-1:0])]);

    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && init_st == INIT_IDLE) |=> imr == $past(bus_wdata));

    a_r13_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> |(irr & ~imr));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int  total = 0, bad = 0;
    bit  done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_a0(bus_a0),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic wr(input logic a0, input logic [7:0] d);
        @(posedge clk); #1 bus_a0 = a0; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    // Driver: push the expected read value, then issue the read.
    task automatic rd(input logic a0, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1 bus_a0 = a0; bus_rd = 1'b1;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic set_in(input logic [7:0] v);
        @(posedge clk); #1 irq_in = v;
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        total++;
        if (irq_out !== e) begin
            bad++;
            $display("FAIL %s: irq_out=%b expected %b", tag, irq_out, e);
        end
    endtask

    task automatic poll(input logic [7:0] e, input string tag);
        wr(1'b0, 8'h0C);
        rd(1'b0, e, tag);
    endtask

    // Monitor: compare each read against the scoreboard head.
    always @(negedge clk) begin
        if (bus_rd && rst_n) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard: rdata=%h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(1'b1, 8'hFF, "R1 mask");
        rd(1'b0, 8'h00, "R1 irr");
        chk_irq(1'b0, "R1 irq");

        // R2 single mode with mode word: vector, mode, then mask
        wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h01); wr(1'b1, 8'hF0);
        rd(1'b1, 8'hF0, "R2 mask after short sequence");
        wr(1'b0, 8'h88); rd(1'b0, 8'h40, "R3 vector");
        wr(1'b0, 8'h8A); rd(1'b0, 8'h01, "R3 mode");
        // R2 single mode, no mode word
        wr(1'b0, 8'h12); wr(1'b1, 8'h55); wr(1'b1, 8'h3C);
        rd(1'b1, 8'h3C, "R2 mask after two words");
        wr(1'b0, 8'h8A); rd(1'b0, 8'h00, "R2 mode cleared");
        wr(1'b0, 8'h88); rd(1'b0, 8'h55, "R3 vector 2");
        // full four-word sequence
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd(1'b1, 8'h00, "R2 mask cleared by init");
        wr(1'b0, 8'h89); rd(1'b0, 8'h04, "R3 cascade");
        wr(1'b0, 8'h88); rd(1'b0, 8'h20, "R3 vector 3");
        wr(1'b0, 8'h8A); rd(1'b0, 8'h01, "R3 mode 3");
        wr(1'b0, 8'h0A);

        // R4 masking, R5 edge capture, R7 poll, R10 views
        wr(1'b1, 8'hFF); rd(1'b1, 8'hFF, "R4 mask readback");
        set_in(8'h08);
        chk_irq(1'b0, "R4 masked");
        rd(1'b0, 8'h08, "R4 request kept while masked");
        wr(1'b1, 8'hF7);
        chk_irq(1'b1, "R4 unmask raises R13");
        poll(8'h83, "R7 poll level 3");
        chk_irq(1'b0, "R5 held input no re-request");
        wr(1'b0, 8'h0B); rd(1'b0, 8'h08, "R10 isr view");
        rd(1'b1, 8'hF7, "R4 mask unchanged");

        // R8 default priority, R9 specific EOI
        wr(1'b1, 8'h00);
        set_in(8'h29);
        chk_irq(1'b1, "R8 level 0 outranks in-service 3");
        poll(8'h80, "R8 poll level 0");
        chk_irq(1'b0, "R8 level 5 blocked");
        wr(1'b0, 8'h60); rd(1'b0, 8'h08, "R9 specific eoi 0");
        chk_irq(1'b0, "R9 still blocked");
        wr(1'b0, 8'h63);
        chk_irq(1'b1, "R9 lower request re-raises");
        poll(8'h85, "R7 poll level 5");
        wr(1'b0, 8'h65); rd(1'b0, 8'h00, "R9 isr empty");

        // R8 rotated priority, R9 non-specific EOI
        set_in(8'h00);
        wr(1'b0, 8'hC2);
        set_in(8'h12);
        poll(8'h84, "R8 rotated 4 before 1");
        wr(1'b0, 8'h64);
        poll(8'h81, "R8 rotated then 1");
        wr(1'b0, 8'h61);
        set_in(8'h00); set_in(8'h81);
        poll(8'h87, "R8 rotated 7 before 0");
        poll(8'h00, "R8 level 0 blocked by 7");
        rd(1'b0, 8'h80, "R7 empty poll leaves isr");
        wr(1'b0, 8'h20); rd(1'b0, 8'h00, "R9 nonspecific clears 7");
        poll(8'h80, "R9 level 0 now served");
        wr(1'b0, 8'h20); rd(1'b0, 8'h00, "R9 nonspecific clears 0");

        // R11 special mask mode
        set_in(8'h00); set_in(8'h20);
        poll(8'h85, "R11 serve level 5");
        wr(1'b1, 8'h20);
        set_in(8'h60);
        chk_irq(1'b0, "R11 blocked without special mask");
        wr(1'b0, 8'h68);
        chk_irq(1'b1, "R11 special mask unblocks");
        poll(8'h86, "R11 poll level 6");
        wr(1'b0, 8'h48); wr(1'b0, 8'h66); wr(1'b0, 8'h65);
        rd(1'b0, 8'h00, "R11 isr cleared");
        wr(1'b1, 8'h00);
        set_in(8'h00);

        // R6 level mode, R12 spurious level 7
        wr(1'b0, 8'h19); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        set_in(8'h80);
        chk_irq(1'b1, "R6 level request");
        rd(1'b0, 8'h80, "R6 irr follows input");
        set_in(8'h00);
        chk_irq(1'b0, "R6 request drops");
        poll(8'h00, "R12 spurious poll");
        wr(1'b0, 8'h0B); rd(1'b0, 8'h00, "R12 isr7 clear");
        set_in(8'h10);
        poll(8'h84, "R6 level poll");
        chk_irq(1'b0, "R6 in-service blocks itself");
        wr(1'b0, 8'h0A); rd(1'b0, 8'h10, "R6 irr held");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule